// File: doc/BRIEF.md
# Audio Sample FIFO with Request Threshold and Error Flags

This block holds audio samples between a bus-side data register and a serial audio shifter. It is an eight-word, 32-bit first-in first-out store. One side pushes samples and the other pops them. A fill-level comparison raises a DMA request when enough words, or enough free space, are available. In receive mode the serializer pushes and the bus pops. In transmit mode the bus pushes and the serializer pops.

Beside the store sits a status unit with six sticky error flags, a per-flag interrupt enable, a write-one-to-clear port and one interrupt line. Three flags come from events the serializer reports: mute detected, wrong clock setup and codec not ready. One flag records store overrun or underrun. The last two come from a frame-sync checker in the block, which watches the sync marks against a programmed frame length while the interface is a clock slave.

Top module: `audio_sample_fifo`

## Requirements
- R1: The store keeps up to DEPTH (default 8) words in arrival order, and `fill_level` never exceeds DEPTH.
- R2: A push while full is dropped. A pop while empty is ignored. Status bit 0 (xrun) is set by a dropped push in receive mode (`rx_mode`=1) and by an ignored pop in transmit mode (`rx_mode`=0).
- R3: A high `flush` empties the store on the next edge. It wins over a push or pop in the same cycle.
- R4: `req_level` selects the request threshold: 0 means 1 word, 1 means DEPTH/4, 2 means DEPTH/2, 3 means 3·DEPTH/4, and 4 means DEPTH. In transmit mode `dma_req` is high while free space is at least the threshold.
- R5: In receive mode `dma_req` is high while the stored word count is at least the threshold.
- R6: `req_level` codes 5 to 7 behave as code 4 (full).
- R7: Status bits are sticky once set. The bits are: 0 xrun, 1 mute detected, 2 wrong clock setup, 3 codec not ready, 4 early frame sync, 5 late frame sync.
- R8: A `clr_wr` pulse clears each status bit whose `clr_bits` bit is 1 and leaves the others alone. An event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit and its `irq_enable` bit are both 1. The enables never alter status.
- R10: `clk_cfg_evt` sets bit 2 only while `master_mode`=1.
- R11: In slave mode a frame is `frame_bits_m1`+1 bit ticks, and a sync tick marks bit 0. A sync tick that comes before the last bit of a tracked frame sets bit 4.
- R12: In slave mode, a tracked frame whose last bit passes with no following sync tick sets bit 5, on the tick after the last bit. Tracking then waits for the next sync.
- R13: While `master_mode`=1, sync timing sets neither bit 4 nor bit 5.
- R14: After reset the store is empty, all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_mode | input | 1 | 1 receive, 0 transmit |
| master_mode | input | 1 | 1 clock master, 0 clock slave |
| push_en | input | 1 | Write one word |
| push_data | input | 32 | Word to write |
| pop_en | input | 1 | Remove the head word |
| pop_data | output | 32 | Head word of the store |
| flush | input | 1 | Empty the store |
| req_level | input | 3 | Request threshold code |
| dma_req | output | 1 | DMA request |
| fill_level | output | 4 | Stored word count |
| mute_evt | input | 1 | Mute detected event |
| clk_cfg_evt | input | 1 | Wrong clock setup event |
| codec_nrdy_evt | input | 1 | Codec not ready event |
| bit_tick | input | 1 | One strobe per serial bit |
| frame_sync | input | 1 | Frame sync mark, sampled with bit_tick |
| frame_bits_m1 | input | 8 | Frame length in bits minus one |
| irq_enable | input | 6 | Per-flag interrupt enable |
| clr_wr | input | 1 | Clear strobe |
| clr_bits | input | 6 | Flags to clear (ones clear) |
| status | output | 6 | Sticky status flags |
| irq | output | 1 | Interrupt |

## Verification
Assertions check every cycle that the fill level stays bounded and that a flush leaves the store empty. They also check that each flag is set by its event, stays set until cleared, and drops after a write-one clear. Further cycle checks cover the full-threshold request in transmit mode, the silence of the sync checker in master mode, and the absence of the clock-setup flag in slave mode. Only the bench scenarios can show the threshold table across both directions, word ordering through the store, drop and ignore behaviour at the edges, and the exact ticks at which early and late syncs are flagged.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    // Number of status flags and their bit positions.
    localparam int FLAG_N    = 6;
    localparam int FLG_XRUN  = 0;
    localparam int FLG_MUTE  = 1;
    localparam int FLG_CKCFG = 2;
    localparam int FLG_CNRDY = 3;
    localparam int FLG_EARLY = 4;
    localparam int FLG_LATE  = 5;

    // Threshold codes.
    localparam logic [2:0] TH_ONE  = 3'd0;
    localparam logic [2:0] TH_FULL = 3'd4;
endpackage

// File: rtl/sample_fifo.sv
// sample_fifo: circular store of DEPTH words. Flush beats push and pop.
// A push while full and a pop while empty are refused and reported as
// single-cycle events. Assumes DEPTH >= 2.
module sample_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             ovf_evt,
    output logic             unf_evt
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, push_ok, pop_ok;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign ovf_evt = push && full && !flush;
    assign unf_evt = pop && empty && !flush;
    assign dout    = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and level upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0);
    assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> level == FULL_LVL);
endmodule

// File: rtl/fifo_req_gen.sv
// fifo_req_gen: turns the fill level and a threshold code into a DMA
// request. Transmit compares free space and receive compares stored words.
// Assumes the level input never exceeds DEPTH.
module fifo_req_gen
    import afifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          rx_mode,
    input  logic [2:0]    code,
    input  logic [LW-1:0] level,
    output logic          req
);
    logic [LW-1:0] th_words;
    logic [LW-1:0] free_words;

    // Threshold in words; codes past full saturate to full.
    always_comb begin
        if (code == TH_ONE)       th_words = LW'(1);
        else if (code >= TH_FULL) th_words = LW'(DEPTH);
        else                      th_words = LW'((DEPTH * int'(code)) / 4);
    end

    assign free_words = LW'(DEPTH) - level;
    assign req = rx_mode ? (level >= th_words) : (free_words >= th_words);
endmodule

// File: rtl/fsync_monitor.sv
// fsync_monitor: follows the bit position inside the frame and flags a
// sync that comes early or a frame that ends with no sync. Inputs are
// sampled only on bit ticks, and the error outputs are one-cycle pulses.
// Assumes tick and sync come from the same clock domain.
module fsync_monitor #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             sync,
    input  logic [CNT_W-1:0] last_pos,
    output logic             early_p,
    output logic             late_p
);
    logic [CNT_W-1:0] pos;
    logic             tracking;

    // Position tracking and error pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            tracking <= 1'b0;
            early_p  <= 1'b0;
            late_p   <= 1'b0;
        end else begin
            early_p <= 1'b0;
            late_p  <= 1'b0;
            if (!enable) begin
                tracking <= 1'b0;
            end else if (tick) begin
                if (sync) begin
                    if (tracking && pos != last_pos) early_p <= 1'b1;
                    pos      <= '0;
                    tracking <= 1'b1;
                end else if (tracking) begin
                    if (pos == last_pos) begin
                        late_p   <= 1'b1;
                        tracking <= 1'b0;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end

    assert_quiet_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !early_p && !late_p);
    assert_late_only_from_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !late_p);
endmodule

// File: rtl/flag_unit.sv
// flag_unit: sticky status flags with write-one-to-clear and a masked
// interrupt. An event in the same cycle as a clear keeps its flag set.
module flag_unit #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_bits : '0;

    // Flag register update: set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_eff) | evt;
    end

    // Interrupt line from the enabled flags.
    assign irq = |(flags & ie);

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_set_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> flags[i]);
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_eff[i]) |=> flags[i]);
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[i] && !evt[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/audio_sample_fifo.sv
// audio_sample_fifo: sample store with threshold DMA request, a frame-sync
// timing checker and a six-flag status/interrupt unit. The clock-setup
// check counts only in master mode and the sync checks only in slave mode.
module audio_sample_fifo
    import afifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              master_mode,
    input  logic              push_en,
    input  logic [WIDTH-1:0]  push_data,
    input  logic              pop_en,
    output logic [WIDTH-1:0]  pop_data,
    input  logic              flush,
    input  logic [2:0]        req_level,
    output logic              dma_req,
    output logic [LW-1:0]     fill_level,
    input  logic              mute_evt,
    input  logic              clk_cfg_evt,
    input  logic              codec_nrdy_evt,
    input  logic              bit_tick,
    input  logic              frame_sync,
    input  logic [CNT_W-1:0]  frame_bits_m1,
    input  logic [FLAG_N-1:0] irq_enable,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_bits,
    output logic [FLAG_N-1:0] status,
    output logic              irq
);
    logic              ovf_evt, unf_evt, early_p, late_p;
    logic [FLAG_N-1:0] evt;

    sample_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_en), .din(push_data),
        .pop(pop_en), .flush(flush), .dout(pop_data), .level(fill_level),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt)
    );

    fifo_req_gen #(.DEPTH(DEPTH)) u_req (
        .rx_mode(rx_mode), .code(req_level), .level(fill_level), .req(dma_req)
    );

    fsync_monitor #(.CNT_W(CNT_W)) u_fsync (
        .clk(clk), .rst_n(rst_n), .enable(!master_mode), .tick(bit_tick),
        .sync(frame_sync), .last_pos(frame_bits_m1),
        .early_p(early_p), .late_p(late_p)
    );

    // Event vector; the mode picks which side's store error counts.
    always_comb begin
        evt            = '0;
        evt[FLG_XRUN]  = rx_mode ? ovf_evt : unf_evt;
        evt[FLG_MUTE]  = mute_evt;
        evt[FLG_CKCFG] = clk_cfg_evt && master_mode;
        evt[FLG_CNRDY] = codec_nrdy_evt;
        evt[FLG_EARLY] = early_p;
        evt[FLG_LATE]  = late_p;
    end

    flag_unit #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_wr(clr_wr),
        .clr_bits(clr_bits), .ie(irq_enable), .flags(status), .irq(irq)
    );

    assert_full_req_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && req_level == TH_FULL && dma_req) |-> fill_level == '0);
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enable == '0) |-> !irq);
    assert_no_ckcfg_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !status[FLG_CKCFG]) |=> !status[FLG_CKCFG]);
endmodule

// File: tb/tb_audio_sample_fifo.sv
module tb_audio_sample_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_mode = 1'b0, master_mode = 1'b0;
    logic        push_en = 1'b0, pop_en = 1'b0, flush = 1'b0;
    logic [31:0] push_data = '0, pop_data;
    logic [2:0]  req_level = 3'd2;
    logic        dma_req;
    logic [3:0]  fill_level;
    logic        mute_evt = 1'b0, clk_cfg_evt = 1'b0, codec_nrdy_evt = 1'b0;
    logic        bit_tick = 1'b0, frame_sync = 1'b0;
    logic [7:0]  frame_bits_m1 = 8'd7;
    logic [5:0]  irq_enable = '0, clr_bits = '0, status;
    logic        clr_wr = 1'b0, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    audio_sample_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .master_mode(master_mode),
        .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
        .pop_data(pop_data), .flush(flush), .req_level(req_level),
        .dma_req(dma_req), .fill_level(fill_level), .mute_evt(mute_evt),
        .clk_cfg_evt(clk_cfg_evt), .codec_nrdy_evt(codec_nrdy_evt),
        .bit_tick(bit_tick), .frame_sync(frame_sync),
        .frame_bits_m1(frame_bits_m1), .irq_enable(irq_enable),
        .clr_wr(clr_wr), .clr_bits(clr_bits), .status(status), .irq(irq)
    );

    // Threshold table: {rx, code[2:0], fill[3:0], expected request}.
    localparam logic [8:0] VEC [18] = '{
        {1'b0, 3'd0, 4'd7, 1'b1}, {1'b0, 3'd0, 4'd8, 1'b0},
        {1'b0, 3'd2, 4'd4, 1'b1}, {1'b0, 3'd2, 4'd5, 1'b0},
        {1'b0, 3'd3, 4'd2, 1'b1}, {1'b0, 3'd3, 4'd3, 1'b0},
        {1'b0, 3'd4, 4'd0, 1'b1}, {1'b0, 3'd4, 4'd1, 1'b0},
        {1'b1, 3'd0, 4'd0, 1'b0}, {1'b1, 3'd0, 4'd1, 1'b1},
        {1'b1, 3'd1, 4'd1, 1'b0}, {1'b1, 3'd1, 4'd2, 1'b1},
        {1'b1, 3'd2, 4'd4, 1'b1}, {1'b1, 3'd3, 4'd5, 1'b0},
        {1'b1, 3'd4, 4'd8, 1'b1}, {1'b1, 3'd4, 4'd7, 1'b0},
        {1'b1, 3'd6, 4'd7, 1'b0}, {1'b0, 3'd7, 4'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [31:0] d);
        push_en = 1'b1; push_data = d; cyc(1); push_en = 1'b0;
    endtask

    task automatic pop1();
        pop_en = 1'b1; cyc(1); pop_en = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; cyc(1); flush = 1'b0;
    endtask

    task automatic clear_all();
        clr_wr = 1'b1; clr_bits = '1; cyc(1); clr_wr = 1'b0; clr_bits = '0;
    endtask

    task automatic send_tick(input logic fs);
        bit_tick = 1'b1; frame_sync = fs; cyc(1);
        bit_tick = 1'b0; frame_sync = 1'b0; cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R14: reset state
        chk("R14 level", 32'(fill_level), 0);
        chk("R14 status", 32'(status), 0);
        chk("R14 irq", 32'(irq), 0);

        // R4 R5 R6: threshold table
        for (int i = 0; i < 18; i++) begin
            rx_mode = VEC[i][8];
            req_level = VEC[i][7:5];
            do_flush();
            for (int k = 0; k < int'(VEC[i][4:1]); k++) push(32'h100 + k);
            chk(VEC[i][8] ? "R5 rx request" : "R4 R6 tx request",
                32'(dma_req), 32'(VEC[i][0]));
        end
        clear_all();

        // R1: arrival order
        rx_mode = 1'b0;
        do_flush();
        push(32'hA1); push(32'hB2); push(32'hC3);
        chk("R1 level", 32'(fill_level), 3);
        chk("R1 head0", pop_data, 32'hA1); pop1();
        chk("R1 head1", pop_data, 32'hB2); pop1();
        chk("R1 head2", pop_data, 32'hC3); pop1();

        // R2: pop on empty in transmit mode
        chk("R2 pre status", 32'(status), 0);
        pop1();
        chk("R2 empty pop level", 32'(fill_level), 0);
        chk("R2 underrun flag", 32'(status[0]), 1);
        clear_all();
        chk("R8 clear xrun", 32'(status), 0);

        // R2: push while full in receive mode
        rx_mode = 1'b1;
        do_flush();
        for (int k = 0; k < 8; k++) push(32'h200 + k);
        push(32'hDEAD);
        chk("R2 full push level", 32'(fill_level), 8);
        chk("R2 overrun flag", 32'(status[0]), 1);
        chk("R2 head kept", pop_data, 32'h200);
        clear_all();

        // R3: flush wins over a push in the same cycle
        flush = 1'b1; push_en = 1'b1; push_data = 32'h55; cyc(1);
        flush = 1'b0; push_en = 1'b0;
        chk("R3 flush level", 32'(fill_level), 0);

        // R7 R8 R9: mute flag, masking, clear
        mute_evt = 1'b1; cyc(1); mute_evt = 1'b0; cyc(1);
        chk("R7 mute sticky", 32'(status), 32'h02);
        chk("R9 masked irq", 32'(irq), 0);
        irq_enable = 6'b000010; #1;
        chk("R9 enabled irq", 32'(irq), 1);
        clr_wr = 1'b1; clr_bits = 6'b111101; cyc(1); clr_wr = 1'b0;
        chk("R8 zero keeps", 32'(status), 32'h02);
        mute_evt = 1'b1; clr_wr = 1'b1; clr_bits = 6'b000010; cyc(1);
        mute_evt = 1'b0; clr_wr = 1'b0;
        chk("R8 set beats clear", 32'(status), 32'h02);
        clear_all();
        chk("R9 irq after clear", 32'(irq), 0);
        irq_enable = '0;

        // R7 codec not ready; R10 clock setup only in master mode
        codec_nrdy_evt = 1'b1; cyc(1); codec_nrdy_evt = 1'b0;
        chk("R7 codec flag", 32'(status), 32'h08);
        clear_all();
        master_mode = 1'b0;
        clk_cfg_evt = 1'b1; cyc(1); clk_cfg_evt = 1'b0;
        chk("R10 slave ignore", 32'(status), 0);
        master_mode = 1'b1;
        clk_cfg_evt = 1'b1; cyc(1); clk_cfg_evt = 1'b0;
        chk("R10 master flag", 32'(status), 32'h04);
        clear_all();

        // R11 R12: slave frame of 8 bits
        master_mode = 1'b0;
        frame_bits_m1 = 8'd7;
        send_tick(1'b1);
        for (int k = 0; k < 7; k++) send_tick(1'b0);
        send_tick(1'b1);
        cyc(2);
        chk("R11 on-time sync", 32'(status), 0);
        for (int k = 0; k < 3; k++) send_tick(1'b0);
        send_tick(1'b1);
        cyc(2);
        chk("R11 early sync", 32'(status), 32'h10);
        clear_all();
        for (int k = 0; k < 7; k++) send_tick(1'b0);
        cyc(2);
        chk("R12 no late yet", 32'(status), 0);
        send_tick(1'b0);
        cyc(2);
        chk("R12 late sync", 32'(status), 32'h20);
        clear_all();

        // R13: master mode ignores sync timing
        master_mode = 1'b1;
        send_tick(1'b1);
        send_tick(1'b0);
        send_tick(1'b1);
        for (int k = 0; k < 10; k++) send_tick(1'b0);
        cyc(2);
        chk("R13 master quiet", 32'(status), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule